// File: doc/BRIEF.md
# Line-Boundary Access Splitter

This block sits between a load/store unit and a data-cache port. Each request carries a byte address, a size code, a direction, and, for stores, data. The data is right-justified and in big-endian order, so the byte at the lowest address is the most significant byte of the value. An access that fits inside one cache line goes to the cache as a single request. An access whose bytes run past the end of a line is cut into two line-local parts, which are issued one after the other. For a load, the two partial results are joined back into one value.

Splitting happens only when the cache is enabled and the crossing-split mode is selected. When the cache is disabled, every access goes out as one request marked uncached. When the cache is enabled but the split mode is off, every access goes out whole. Both mode pins are sampled when a request is accepted.

Back-pressure rules:
- The request side is valid/ready. `req_ready` is high only while no access is in flight.
- The cache side is valid/ready. Once `cp_valid` is raised, it stays high and every request field stays constant until `cp_ready` is seen high.
- The cache response and the upstream response have no ready signal. They are single-cycle pulses.
- The cache must return load data in request order.

Top module: `line_cross_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and `cp_valid`, `rsp_valid` and `wr_done` are 0.
- R2: The size code gives the byte count: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. An access passes as one cache request, with the same address, a length equal to the byte count and the data unchanged, when its in-line offset (address modulo LINE_BYTES) plus its byte count is not greater than LINE_BYTES. This includes an access that ends exactly on the last byte of a line.
- R3: When the cache and split mode are both enabled and offset plus byte count exceeds LINE_BYTES, two requests are issued. The first starts at the original address with length LINE_BYTES minus the offset. The second starts at the original address plus that length, which is the start of the next line, with the remaining byte count.
- R4: The second part is presented only after the first part is accepted. While `cp_valid` is high and `cp_ready` is low, the address, length and data of the request on `cp_*` do not change.
- R5: For a split store, the first part carries the leading (most significant) bytes of the value, right-justified. The second part carries the remaining low bytes.
- R6: A load produces exactly one `rsp_valid` pulse, one cycle after the cache returns its final part. For a split load, the data from the first part fills the most significant bytes of the result.
- R7: A store pulses `wr_done` for one cycle, in the cycle after its last part is accepted. A store never raises `rsp_valid`.
- R8: With `cache_en` low at acceptance, a line-crossing access is sent as one request of full length with `cp_uncached` high.
- R9: With `cache_en` high and `split_en` low at acceptance, a line-crossing access is sent as one request of full length with `cp_uncached` low.
- R10: `req_ready` stays low from the acceptance of a request until the cycle its completion pulse (`rsp_valid` or `wr_done`) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Data cache enabled; sampled at acceptance |
| split_en | input | 1 | Crossing-split mode selected; sampled at acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SIZE_W | Size code (0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes) |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 8*MAX_BYTES | Store value, right-justified, big-endian |
| cp_valid | output | 1 | Cache request valid |
| cp_ready | input | 1 | Cache accepts request |
| cp_addr | output | ADDR_W | Cache request address |
| cp_len | output | LEN_W | Cache request byte count |
| cp_write | output | 1 | Cache request direction |
| cp_wdata | output | 8*MAX_BYTES | Cache store bytes, right-justified |
| cp_uncached | output | 1 | Access bypasses the cache |
| cr_valid | input | 1 | Cache load response pulse |
| cr_rdata | input | 8*MAX_BYTES | Cache load bytes, right-justified |
| rsp_valid | output | 1 | Load result pulse |
| rsp_rdata | output | 8*MAX_BYTES | Load result, right-justified |
| wr_done | output | 1 | Store completion pulse |

## Verification
On every cycle, the embedded properties check several rules:
- requests stay stable under back-pressure,
- a second part always starts on a line boundary,
- no split part reaches past its line,
- the two part lengths add up to the access size,
- completion pulses last a single cycle,
- the request side stays closed while a cache request is pending.

Some behaviour only the directed scenarios can show: the exact split points and addresses, the byte routing of store data into the two parts, the reassembled load value, the completion timing, and the effect of the two mode pins on whether an access is split.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PART1 = 2'd1,
    ST_PART2 = 2'd2,
    ST_WAIT  = 2'd3
  } lsplit_state_e;

endpackage

// File: rtl/lsplit_plan.sv
// Decides whether an access crosses a line and computes the two part lengths.
module lsplit_plan #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned MAX_BYTES  = 8,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned LEN_W  = $clog2(MAX_BYTES) + 1,
  localparam int unsigned SIZE_W = $clog2($clog2(MAX_BYTES) + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size_code,
  input  logic              allow_split,
  output logic              crosses,
  output logic [LEN_W-1:0]  total,
  output logic [LEN_W-1:0]  len1,
  output logic [LEN_W-1:0]  len2,
  output logic [ADDR_W-1:0] addr2
);

  always_comb begin
    int unsigned off_i;
    int unsigned tot_i;
    int unsigned head_i;
    off_i   = int'(addr[OFF_W-1:0]);
    tot_i   = 32'd1 << size_code;
    head_i  = LINE_BYTES - off_i;
    total   = LEN_W'(tot_i);
    crosses = allow_split && ((off_i + tot_i) > LINE_BYTES);
    if (crosses) begin
      len1 = LEN_W'(head_i);
      len2 = LEN_W'(tot_i - head_i);
    end else begin
      len1 = LEN_W'(tot_i);
      len2 = '0;
    end
    addr2 = addr + ADDR_W'(len1);
  end

endmodule

// File: rtl/lsplit_merge.sv
// Holds the first partial load result and joins it with the second.
module lsplit_merge #(
  parameter int unsigned MAX_BYTES = 8,
  localparam int unsigned DATA_W = 8 * MAX_BYTES,
  localparam int unsigned LEN_W  = $clog2(MAX_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_hi,
  input  logic [DATA_W-1:0] rd_in,
  input  logic              is_split,
  input  logic [LEN_W-1:0]  len2,
  input  logic [LEN_W-1:0]  total,
  output logic [DATA_W-1:0] merged
);

  function automatic logic [DATA_W-1:0] lo_mask(input logic [LEN_W-1:0] n);
    if (int'(n) >= MAX_BYTES) return '1;
    return (DATA_W'(1) << (8 * int'(n))) - DATA_W'(1);
  endfunction

  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (cap_hi) hi_q <= rd_in;
  end

  always_comb begin
    if (is_split) merged = (hi_q << (8 * int'(len2))) | (rd_in & lo_mask(len2));
    else          merged = rd_in & lo_mask(total);
  end

endmodule

// File: rtl/line_cross_splitter.sv
module line_cross_splitter #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned MAX_BYTES  = 8,
  localparam int unsigned DATA_W = 8 * MAX_BYTES,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned LEN_W  = $clog2(MAX_BYTES) + 1,
  localparam int unsigned SIZE_W = $clog2($clog2(MAX_BYTES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              split_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cp_valid,
  input  logic              cp_ready,
  output logic [ADDR_W-1:0] cp_addr,
  output logic [LEN_W-1:0]  cp_len,
  output logic              cp_write,
  output logic [DATA_W-1:0] cp_wdata,
  output logic              cp_uncached,
  input  logic              cr_valid,
  input  logic [DATA_W-1:0] cr_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_done
);
  import lsplit_pkg::*;

  function automatic logic [DATA_W-1:0] lo_mask(input logic [LEN_W-1:0] n);
    if (int'(n) >= MAX_BYTES) return '1;
    return (DATA_W'(1) << (8 * int'(n))) - DATA_W'(1);
  endfunction

  lsplit_state_e     st_q;
  logic [ADDR_W-1:0] addr_q, addr2_q;
  logic [LEN_W-1:0]  tot_q, len1_q, len2_q;
  logic [DATA_W-1:0] wd_q, rsp_rdata_q, merged;
  logic              wr_q, unc_q, split_q, got_q;
  logic              rsp_valid_q, wr_done_q;

  logic              pl_cross;
  logic [LEN_W-1:0]  pl_tot, pl_len1, pl_len2;
  logic [ADDR_W-1:0] pl_addr2;

  lsplit_plan #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)) u_plan (
    .addr(req_addr), .size_code(req_size), .allow_split(cache_en && split_en),
    .crosses(pl_cross), .total(pl_tot), .len1(pl_len1), .len2(pl_len2), .addr2(pl_addr2)
  );

  logic accept, issue_ok, rd_resp, cap_first;
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cp_valid  = (st_q == ST_PART1) || (st_q == ST_PART2);
  assign issue_ok  = cp_valid && cp_ready;
  assign rd_resp   = cr_valid && !wr_q && (st_q != ST_IDLE);
  assign cap_first = rd_resp && split_q && !got_q;

  lsplit_merge #(.MAX_BYTES(MAX_BYTES)) u_merge (
    .clk(clk), .rst_n(rst_n), .cap_hi(cap_first), .rd_in(cr_rdata),
    .is_split(split_q), .len2(len2_q), .total(tot_q), .merged(merged)
  );

  always_comb begin
    cp_addr     = (st_q == ST_PART2) ? addr2_q : addr_q;
    cp_write    = wr_q;
    cp_uncached = unc_q;
    if (!split_q)              begin cp_len = tot_q;  cp_wdata = wd_q; end
    else if (st_q == ST_PART2) begin cp_len = len2_q; cp_wdata = wd_q & lo_mask(len2_q); end
    else                       begin cp_len = len1_q; cp_wdata = wd_q >> (8 * int'(len2_q)); end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      addr_q <= '0; addr2_q <= '0; tot_q <= '0; len1_q <= '0; len2_q <= '0;
      wd_q <= '0; wr_q <= 1'b0; unc_q <= 1'b0; split_q <= 1'b0; got_q <= 1'b0;
      rsp_valid_q <= 1'b0; rsp_rdata_q <= '0; wr_done_q <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      wr_done_q   <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_PART1;
          addr_q  <= req_addr;  addr2_q <= pl_addr2;
          tot_q   <= pl_tot;    len1_q  <= pl_len1;  len2_q <= pl_len2;
          wd_q    <= req_wdata; wr_q    <= req_write;
          unc_q   <= !cache_en; split_q <= pl_cross; got_q  <= 1'b0;
        end
        ST_PART1: if (issue_ok) begin
          if (split_q)   st_q <= ST_PART2;
          else if (wr_q) begin st_q <= ST_IDLE; wr_done_q <= 1'b1; end
          else           st_q <= ST_WAIT;
        end
        ST_PART2: if (issue_ok) begin
          if (wr_q) begin st_q <= ST_IDLE; wr_done_q <= 1'b1; end
          else      st_q <= ST_WAIT;
        end
        default: ;
      endcase
      if (cap_first) got_q <= 1'b1;
      if (rd_resp && st_q == ST_WAIT && !(split_q && !got_q)) begin
        rsp_valid_q <= 1'b1;
        rsp_rdata_q <= merged;
        st_q        <= ST_IDLE;
        got_q       <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign wr_done   = wr_done_q;

  // R4: request held steady under back-pressure
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && !cp_ready |=> cp_valid && $stable(cp_addr) && $stable(cp_len) && $stable(cp_wdata));
  // R3: second part begins at a line start
  a_r3_part2_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && st_q == ST_PART2 |-> cp_addr[OFF_W-1:0] == '0);
  // R3: every split part stays within its line
  a_r3_part_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && split_q |-> (int'(cp_addr[OFF_W-1:0]) + int'(cp_len)) <= LINE_BYTES);
  // R3: part lengths add to the access size
  a_r3_len_sum: assert property (@(posedge clk) disable iff (!rst_n)
    split_q && st_q != ST_IDLE |-> (int'(len1_q) + int'(len2_q)) == int'(tot_q));
  // R6: load result is a one-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R7: store completion is a one-cycle pulse and never with a load result
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> !rsp_valid ##1 !wr_done);
  // R10: request side closed while a cache request is pending
  a_r10_busy_closed: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid |-> !req_ready);

endmodule

// File: tb/tb_line_cross_splitter.sv
`timescale 1ns/1ps
module tb_line_cross_splitter;
  localparam int LINE = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cache_en = 1'b1, split_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, cp_valid, cp_write, cp_uncached, rsp_valid, wr_done;
  logic cp_ready = 1'b1, cr_valid = 1'b0;
  logic [31:0] cp_addr;
  logic [3:0]  cp_len;
  logic [63:0] cp_wdata, rsp_rdata;
  logic [63:0] cr_rdata = '0;

  always #4 clk = ~clk;

  line_cross_splitter dut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .split_en(split_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .cp_valid(cp_valid), .cp_ready(cp_ready),
    .cp_addr(cp_addr), .cp_len(cp_len), .cp_write(cp_write), .cp_wdata(cp_wdata),
    .cp_uncached(cp_uncached), .cr_valid(cr_valid), .cr_rdata(cr_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_done(wr_done)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ 8'h3C ^ {a[11:8], 4'h0};
  endfunction
  function automatic logic [63:0] beval(input logic [31:0] a, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(mb(a + 32'(i)));
    return v;
  endfunction
  function automatic logic [63:0] bmask(input int n);
    if (n >= 8) return '1;
    return (64'd1 << (8 * n)) - 64'd1;
  endfunction

  // cache model: ready pattern, request log, in-order load responses
  bit stall_mode = 0;
  int cyc = 0;
  int log_n = 0;
  logic [31:0] lg_addr [4];
  logic [3:0]  lg_len  [4];
  logic [63:0] lg_wd   [4];
  logic        lg_unc  [4];
  time last_acc_t, last_rsp_t;
  logic [31:0] pq_addr [4];
  int pq_len [4], pq_due [4];
  int pq_h = 0, pq_t = 0;
  bit hold_pend = 0;
  logic [31:0] h_addr; logic [3:0] h_len; logic [63:0] h_wd;

  always @(negedge clk) begin
    cyc++;
    cp_ready = stall_mode ? (cyc % 3 == 2) : 1'b1;
    if (hold_pend)
      chk(cp_valid && cp_addr == h_addr && cp_len == h_len && cp_wdata == h_wd,
          "R4 request changed under back-pressure", {cp_addr, 28'd0, cp_len}, {h_addr, 28'd0, h_len});
    hold_pend = cp_valid && !cp_ready;
    h_addr = cp_addr; h_len = cp_len; h_wd = cp_wdata;
    cr_valid = 1'b0;
    if (pq_h != pq_t && cyc >= pq_due[pq_h % 4]) begin
      cr_valid = 1'b1;
      cr_rdata = beval(pq_addr[pq_h % 4], pq_len[pq_h % 4]);
      pq_h++;
      last_rsp_t = $time;
    end
    if (cp_valid && cp_ready) begin
      if (log_n < 4) begin
        lg_addr[log_n] = cp_addr; lg_len[log_n] = cp_len;
        lg_wd[log_n] = cp_wdata;  lg_unc[log_n] = cp_uncached;
      end
      log_n++;
      last_acc_t = $time;
      if (!cp_write) begin
        pq_addr[pq_t % 4] = cp_addr; pq_len[pq_t % 4] = int'(cp_len); pq_due[pq_t % 4] = cyc + 2;
        pq_t++;
      end
    end
  end

  // global watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  logic [63:0] got;
  bit busy_ok, saw_rsp, to;
  time done_t;

  task automatic run(input logic [31:0] a, input int sc, input bit wr, input logic [63:0] wd,
                     input bit ce, input bit se, input bit stall);
    @(negedge clk);
    log_n = 0; stall_mode = stall; cache_en = ce; split_en = se;
    req_addr = a; req_size = 2'(sc); req_write = wr; req_wdata = wd; req_valid = 1'b1;
    busy_ok = 1; saw_rsp = 0; to = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (wr && wr_done) break;
      if (!wr && rsp_valid) break;
      if (rsp_valid) saw_rsp = 1;
      if (req_ready) busy_ok = 0;
      if (k == 299) to = 1;
      @(negedge clk);
    end
    done_t = $time;
    got = rsp_rdata;
    chk(!to, "R10 completion timeout", 64'(to), 0);
    chk(busy_ok, "R10 req_ready high while busy", 64'(busy_ok), 1);
    @(negedge clk);
    chk(!rsp_valid && !wr_done, "R6 R7 completion pulse longer than one cycle",
        {62'd0, rsp_valid, wr_done}, 0);
    stall_mode = 0;
  endtask

  task automatic chk_part(input int i, input logic [31:0] a, input int len, input string tag);
    chk(lg_addr[i] == a, {tag, " part address"}, 64'(lg_addr[i]), 64'(a));
    chk(int'(lg_len[i]) == len, {tag, " part length"}, 64'(lg_len[i]), 64'(len));
  endtask

  task automatic t_reset;
    chk(req_ready && !cp_valid && !rsp_valid && !wr_done, "R1 reset state",
        {60'd0, req_ready, cp_valid, rsp_valid, wr_done}, 64'h8);
  endtask

  task automatic t_pass_read;
    run(32'h0000_0104, 2, 0, 0, 1, 1, 0);
    chk(log_n == 1, "R2 inline load one request", 64'(log_n), 1);
    chk_part(0, 32'h104, 4, "R2");
    chk(got == beval(32'h104, 4), "R6 inline load data", got, beval(32'h104, 4));
    chk(done_t == last_rsp_t + 8, "R6 load result timing", 64'(done_t), 64'(last_rsp_t + 8));
  endtask

  task automatic t_pass_write_edge;
    logic [63:0] wd = 64'h0123_4567_89AB_CDEF;
    run(32'h0000_0018, 3, 1, wd, 1, 1, 0);
    chk(log_n == 1, "R2 store ending on last line byte not split", 64'(log_n), 1);
    chk_part(0, 32'h18, 8, "R2");
    chk(lg_wd[0] == wd, "R2 store data unchanged", lg_wd[0], wd);
    chk(!saw_rsp, "R7 store raised rsp_valid", 64'(saw_rsp), 0);
  endtask

  task automatic t_split_read(input logic [31:0] a, input int sc, input bit stall);
    int tot = 1 << sc;
    int off = int'(a % LINE);
    int l1 = LINE - off;
    run(a, sc, 0, 0, 1, 1, stall);
    chk(log_n == 2, "R3 crossing load two requests", 64'(log_n), 2);
    chk_part(0, a, l1, "R3 first");
    chk_part(1, a + 32'(l1), tot - l1, "R3 second");
    chk(got == beval(a, tot), "R6 rebuilt load data", got, beval(a, tot));
    chk(done_t == last_rsp_t + 8, "R6 load result timing", 64'(done_t), 64'(last_rsp_t + 8));
  endtask

  task automatic t_split_write(input logic [31:0] a, input int sc, input logic [63:0] wd, input bit stall);
    int tot = 1 << sc;
    int l1 = LINE - int'(a % LINE);
    int l2 = tot - l1;
    run(a, sc, 1, wd, 1, 1, stall);
    chk(log_n == 2, "R3 crossing store two requests", 64'(log_n), 2);
    chk_part(0, a, l1, "R3 first");
    chk_part(1, a + 32'(l1), l2, "R3 second");
    chk(lg_wd[0] == (wd >> (8 * l2)), "R5 leading store bytes", lg_wd[0], wd >> (8 * l2));
    chk(lg_wd[1] == (wd & bmask(l2)), "R5 trailing store bytes", lg_wd[1], wd & bmask(l2));
    chk(done_t == last_acc_t + 8, "R7 store completion timing", 64'(done_t), 64'(last_acc_t + 8));
    chk(!saw_rsp, "R7 store raised rsp_valid", 64'(saw_rsp), 0);
  endtask

  task automatic t_uncached;
    run(32'h0000_021E, 2, 0, 0, 0, 1, 0);
    chk(log_n == 1, "R8 uncached crossing load not split", 64'(log_n), 1);
    chk_part(0, 32'h21E, 4, "R8");
    chk(lg_unc[0] == 1'b1, "R8 uncached flag", 64'(lg_unc[0]), 1);
    chk(got == beval(32'h21E, 4), "R8 uncached load data", got, beval(32'h21E, 4));
  endtask

  task automatic t_split_off;
    logic [63:0] wd = 64'h1122_3344;
    run(32'h0000_033E, 2, 1, wd, 1, 0, 0);
    chk(log_n == 1, "R9 split mode off not split", 64'(log_n), 1);
    chk_part(0, 32'h33E, 4, "R9");
    chk(lg_unc[0] == 1'b0, "R9 cached flag", 64'(lg_unc[0]), 0);
    chk(lg_wd[0] == wd, "R9 store data whole", lg_wd[0], wd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass_read();
    t_pass_write_edge();
    t_split_read(32'h0000_001E, 2, 0);
    t_split_read(32'h0000_003D, 3, 1);
    t_split_read(32'h0000_045F, 1, 1);
    t_split_write(32'h0000_005F, 1, 64'hBEEF, 0);
    t_split_write(32'h0000_007B, 3, 64'hA1B2_C3D4_E5F6_0718, 1);
    t_uncached();
    t_split_off();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule